// File: doc/BRIEF.md
# Ping-Pong Video Line Buffer

This block is the video output stage of a frame store. It holds two line buffers; each holds one scan line of `WORDS` entries of `WORD_W` bits (by default 40 entries of 16 bits, 640 bits in all). A loader writes a whole scan line into the idle buffer in a single clock. It takes the line out of a memory page that carries `LINES` scan lines, using a line index that it supplies with the load. While that happens, the other buffer streams one entry per enabled video clock onto the output.

A position counter runs modulo `WORDS`. When it wraps, the roles of the two buffers swap. The stream then continues without a gap from entry 0 of the freshly loaded buffer, and the buffer that has just been drained becomes free for the next load. A video clock enable stops the whole output side. A load aimed at the buffer that is currently streaming is refused and reported.

Top module: `vid_pingpong_buf`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `vid_data` is 0, `vid_bank` is 0 and `ld_err` is 0. Every entry of both buffers is cleared to 0.
- R2: When `ld_en` is high and `ld_buf` differs from `vid_bank`, the buffer named by `ld_buf` takes scan line `ld_line` of `ld_page` in one clock. Line n occupies bits [n*WORDS*WORD_W +: WORDS*WORD_W] of `ld_page`.
- R3: Entry k of a line is bits [k*WORD_W +: WORD_W] of that line. Entries leave in ascending order starting at 0, one per clock in which `vid_en` is high. `vid_data` is registered and shows the entry in the cycle that follows the enabled edge.
- R4: After `WORDS` enabled clocks the position returns to 0 and `vid_bank` toggles at that same edge. The next enabled clock outputs entry 0 of the other buffer, with no idle cycle between the two lines.
- R5: While `vid_en` is low, the position, `vid_bank` and `vid_data` all hold their values.
- R6: A load into the idle buffer in the same cycle as streaming leaves the streamed entries unchanged.
- R7: When `ld_en` is high and `ld_buf` equals `vid_bank`, no buffer changes and `ld_err` is high for exactly the following cycle. In every other case `ld_err` is low.
- R8: Buffer encoding: the value 0 on `ld_buf` or `vid_bank` names buffer A, and 1 names buffer B. `vid_bank` shows the buffer that is currently streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load request for one cycle |
| ld_buf | input | 1 | Target buffer of the load (0 = A, 1 = B) |
| ld_line | input | LINE_W | Scan-line index within the page |
| ld_page | input | LINES*WORDS*WORD_W | Whole memory page |
| vid_en | input | 1 | Video clock enable |
| vid_data | output | WORD_W | Registered output entry |
| vid_bank | output | 1 | Buffer currently streaming |
| ld_err | output | 1 | Refused load, one cycle after the request |

## Verification
The bench builds the block with 4-bit entries, 5 entries per line and 4 lines per page. With these values a wrap comes every five enabled clocks, so the full load, stream and swap cycle repeats many times in a short run. Every line index goes into both buffers, so all eight buffer and line pairs are covered. Refused loads, enable gaps and loads that coincide with streaming land at several different positions in the line, and each expected entry is computed from the page pattern formula.

// File: rtl/vpb_pkg.sv
package vpb_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;

  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vpb_line_pick.sv
module vpb_line_pick #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 40,
  parameter int LINES  = 16,
  parameter int LINE_W = 4,
  localparam int LINE_BITS = WORDS * WORD_W,
  localparam int PAGE_W    = LINES * LINE_BITS
) (
  input  logic [PAGE_W-1:0]    page_i,
  input  logic [LINE_W-1:0]    line_idx,
  output logic [LINE_BITS-1:0] line_o
);
  // Select one scan line of the page; an out-of-range index gives zeros.
  always_comb begin
    line_o = '0;
    for (int l = 0; l < LINES; l++) begin
      if (line_idx == LINE_W'(l)) line_o = page_i[l*LINE_BITS +: LINE_BITS];
    end
  end
endmodule

// File: rtl/vpb_bank.sv
module vpb_bank #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 40,
  parameter int POS_W  = 6,
  localparam int LINE_BITS = WORDS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [LINE_BITS-1:0] line_i,
  input  logic [POS_W-1:0]     rd_pos,
  output logic [WORD_W-1:0]    rd_word,
  output logic [LINE_BITS-1:0] store_o
);
  logic [LINE_BITS-1:0] store;

  always_ff @(posedge clk) begin
    if (rst)     store <= '0;
    else if (we) store <= line_i;
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (rd_pos == POS_W'(k)) rd_word = store[k*WORD_W +: WORD_W];
    end
  end

  assign store_o = store;

  // R6: without a write strobe the contents stay put
  a_r6_hold_unwritten: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(store));
endmodule

// File: rtl/vpb_seq.sv
module vpb_seq #(
  parameter int WORDS = 40,
  parameter int POS_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [POS_W-1:0]  pos,
  output vpb_pkg::bank_e    act
);
  import vpb_pkg::*;
  localparam logic [POS_W-1:0] LAST = POS_W'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      act <= BANK_A;
    end else if (adv) begin
      if (pos == LAST) begin
        pos <= '0;
        act <= (act == BANK_A) ? BANK_B : BANK_A;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  a_r3_pos_range: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST);
  a_r4_wrap_swaps: assert property (@(posedge clk) disable iff (rst)
    (adv && pos == LAST) |=> (pos == '0) && (act != $past(act)));
  a_r5_pos_frozen: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos) && $stable(act));
endmodule

// File: rtl/vid_pingpong_buf.sv
module vid_pingpong_buf #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 40,
  parameter int LINES  = 16,
  localparam int LINE_W    = vpb_pkg::idx_w(LINES),
  localparam int POS_W     = vpb_pkg::idx_w(WORDS),
  localparam int LINE_BITS = WORDS * WORD_W,
  localparam int PAGE_W    = LINES * LINE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_buf,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic              vid_en,
  output logic [WORD_W-1:0] vid_data,
  output logic              vid_bank,
  output logic              ld_err
);
  import vpb_pkg::*;

  logic [POS_W-1:0]     pos;
  bank_e                act;
  logic [LINE_BITS-1:0] line_sel;
  logic                 clash;
  logic [1:0]           bank_we;
  logic [WORD_W-1:0]    bank_word [2];
  logic [LINE_BITS-1:0] bank_store [2];

  vpb_seq #(.WORDS(WORDS), .POS_W(POS_W)) seq_i (
    .clk(clk), .rst(rst), .adv(vid_en), .pos(pos), .act(act)
  );

  vpb_line_pick #(.WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES), .LINE_W(LINE_W)) pick_i (
    .page_i(ld_page), .line_idx(ld_line), .line_o(line_sel)
  );

  assign clash = ld_en && (ld_buf == logic'(act));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_we[b] = ld_en && !clash && (ld_buf == 1'(b));
    vpb_bank #(.WORD_W(WORD_W), .WORDS(WORDS), .POS_W(POS_W)) bank_i (
      .clk(clk), .rst(rst), .we(bank_we[b]), .line_i(line_sel),
      .rd_pos(pos), .rd_word(bank_word[b]), .store_o(bank_store[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_data <= '0;
      ld_err   <= 1'b0;
    end else begin
      if (vid_en) vid_data <= bank_word[act];
      ld_err <= clash;
    end
  end

  assign vid_bank = logic'(act);

  // R7: a load aimed at the streaming buffer changes nothing and is flagged
  a_r7_refused_load: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_buf == vid_bank) |=> ld_err && $stable(bank_store[0]) && $stable(bank_store[1]));
  // R5: output frozen while the enable is low
  a_r5_output_frozen: assert property (@(posedge clk) disable iff (rst)
    !vid_en |=> $stable(vid_data) && $stable(vid_bank));
  // R7: no error without a request
  a_r7_err_needs_req: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> !ld_err);
endmodule

// File: tb/vid_pingpong_buf_tb_top.sv
module vid_pingpong_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 4;
  localparam int NW = 5;
  localparam int NL = 4;
  localparam int LW = 2;
  localparam int LB = NW * WW;
  localparam int PW = NL * LB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic ld_buf = 1'b0;
  logic [LW-1:0] ld_line = '0;
  logic [PW-1:0] ld_page = '0;
  logic vid_en = 1'b0;
  logic [WW-1:0] vid_data;
  logic vid_bank;
  logic ld_err;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [WW-1:0] m [2][NW];
  int act_m = 0;
  int cnt_m = 0;
  logic [WW-1:0] exp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_pingpong_buf #(.WORD_W(WW), .WORDS(NW), .LINES(NL)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_buf(ld_buf), .ld_line(ld_line),
    .ld_page(ld_page), .vid_en(vid_en), .vid_data(vid_data),
    .vid_bank(vid_bank), .ld_err(ld_err)
  );

  function automatic logic [WW-1:0] pat(input int seed, input int l, input int k);
    return WW'(seed * 7 + l * 5 + k * 3 + 1);
  endfunction

  function automatic logic [PW-1:0] mkpage(input int seed);
    logic [PW-1:0] p;
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < NW; k++)
        p[(l*NW + k)*WW +: WW] = pat(seed, l, k);
    return p;
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit en, input bit ld, input bit lbuf, input int lline, input int seed);
    bit e_err;
    vid_en  = en;
    ld_en   = ld;
    ld_buf  = lbuf;
    ld_line = LW'(lline);
    ld_page = mkpage(seed);
    @(posedge clk); #1;
    e_err = ld && (int'(lbuf) == act_m);
    if (en) exp_data = m[act_m][cnt_m];        // read before any load (R6)
    if (ld && !e_err)                            // R2 load into idle buffer
      for (int k = 0; k < NW; k++) m[lbuf][k] = pat(seed, lline, k);
    if (en) begin
      if (cnt_m == NW - 1) begin cnt_m = 0; act_m = 1 - act_m; end
      else cnt_m++;
    end
    if (!en)      check("R5 data held", int'(vid_data), int'(exp_data));
    else if (ld)  check("R6 data during load", int'(vid_data), int'(exp_data));
    else          check("R2 R3 data", int'(vid_data), int'(exp_data));
    check("R4 R8 vid_bank", int'(vid_bank), act_m);
    check(e_err ? "R7 error flag" : "R7 no error", int'(ld_err), int'(e_err));
    ld_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int k = 0; k < NW; k++) m[b][k] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset data", int'(vid_data), 0);
    check("R1 reset bank", int'(vid_bank), 0);
    check("R1 reset err", int'(ld_err), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1 data after reset", int'(vid_data), 0);
    // R1: buffer A streams cleared contents
    for (int k = 0; k < NW; k++) step(1'b1, 1'b0, 1'b0, 0, 0);
    // rounds: load idle buffer, stream, refuse a clashing load, freeze
    for (int r = 0; r < 9; r++) begin
      int line = (r < 4) ? (r % NL) : ((r + 1) % NL);
      for (int c = 0; c < NW; c++) begin
        if (c == 0 && r < 8) step(1'b1, 1'b1, 1'(1 - act_m), line, r + 1); // R2
        else if (c == 2) begin
          step(1'b1, 1'b1, 1'(act_m), (line + 1) % NL, 99);              // R7
          repeat (r % 3 + 1) step(1'b0, 1'b0, 1'b0, 0, 0);               // R5
          step(1'b0, 1'b1, 1'(act_m), 0, 77);                            // R7 frozen
        end
        else step(1'b1, 1'b0, 1'b0, 0, 0);
      end
    end
    // R4: last line wraps back
    for (int k = 0; k < NW; k++) step(1'b1, 1'b0, 1'b0, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule